// File: doc/BRIEF.md
# SDRAM Data Mask and Clock Suspend Pipeline

This block is the device-side data I/O control inside a synchronous DRAM behavioural model. It sits between the storage array and the data pins. Read beats arrive from the array with a valid flag. The block decides whether each beat is driven on the data pins, and shows high impedance as a low output enable. Write beats arrive from the pins with a valid flag. The block turns each one into a per-beat write strobe and a burst position for the array.

Two controls shape the traffic. The first is the data mask input. On reads it acts two advancing clocks late: a mask sampled high at one advancing edge silences the read beat captured two advancing edges later. On writes it acts at once: a mask high at an edge blocks the write strobe for that same edge. The second control is the clock enable. While it is low, the internal clock is frozen, so bursts, the mask pipeline and the burst position all hold. Entry into the freeze and exit from it each take effect one clock after the clock enable change is sampled.

Three small state machines do the work. The clock machine has the states CLK_RUN and CLK_FROZEN. It goes from CLK_RUN to CLK_FROZEN when the clock enable is sampled low, and from CLK_FROZEN back to CLK_RUN when the clock enable is sampled high. The read machine has the states RD_IDLE, RD_DRIVE and RD_MASKED. At every advancing edge it moves to RD_IDLE when no beat is offered, to RD_MASKED when the beat is masked, and to RD_DRIVE when the beat is driven. The write machine has the states WR_IDLE and WR_BURST. It moves to WR_BURST on an accepted beat that is not the last of the burst, and back to WR_IDLE on the last beat or on a gap.

Top module: `sdram_dq_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it is released, `dq_oe` is 0, `wr_en` is 0 even if `wr_valid` is 1, `frozen` is 0 and `wr_pos` is 0.
- R2: A read beat offered at an advancing edge, with `dqm` low at the advancing edge two advancing edges before, gives `dq_oe`=1 and `dq_out` equal to that beat after the edge.
- R3: If `dqm` is high at an advancing edge, the read beat offered two advancing edges later gives `dq_oe`=0 and `dq_out`=0 after its edge.
- R4: If `rd_valid` is low at an advancing edge, `dq_oe` is 0 after that edge, whatever the value of `dqm`.
- R5: While the clock is not frozen, `wr_en` equals `wr_valid` AND NOT `dqm` in the same cycle (zero latency), and `wr_word` equals `wr_data`.
- R6: A write beat at an advancing edge moves `wr_pos` on by one, even when `dqm` blocks its strobe.
- R7: `wr_pos` counts 0 to BURST_LEN-1 and then wraps to 0. An advancing edge with `wr_valid` low sets it to 0.
- R8: `cke` sampled low at edge k sets `frozen`=1 after edge k. Edge k itself still advances.
- R9: `cke` sampled high at an edge while frozen clears `frozen` after that edge. The next edge advances.
- R10: At an edge while `frozen`=1, `dq_oe`, `dq_out`, `wr_pos` and the stored `dqm` history do not change, and `wr_en` is 0. The values of `dqm`, `rd_valid` and `rd_data` at such an edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low requests the frozen internal clock |
| dqm | input | 1 | Data mask: read disable and write block |
| rd_valid | input | 1 | A read beat from the array is offered |
| rd_data | input | DATA_W | Read beat from the array |
| wr_valid | input | 1 | A write beat from the pins is offered |
| wr_data | input | DATA_W | Write beat from the pins |
| dq_oe | output | 1 | Output enable for the data pins; 0 means high impedance |
| dq_out | output | DATA_W | Data driven on the pins; 0 when not driving |
| wr_en | output | 1 | Write strobe to the array for this edge |
| wr_word | output | DATA_W | Word to be written at this edge |
| wr_pos | output | $clog2(BURST_LEN) | Burst position of the current write beat |
| frozen | output | 1 | The internal clock is frozen |

## Verification
The read path is tested in three ways. A burst with the mask held low checks that beats are driven with the correct single-register delay. A burst with the mask toggling checks that each silenced beat comes exactly two advancing edges after its mask. An idle stretch with the mask toggling checks that the mask cannot keep the output enabled. The write path is tested with a burst that has one blocked beat, which shows that the strobe and the position behave differently. It is also tested with a long stream that crosses the wrap and a burst cut short by a gap. Freeze windows are placed inside a read burst and inside a write burst. During each window the mask, the data and the valid flags are changed. This shows that the edges that freeze and thaw still count one clock late, and that a mask given before the freeze still hits the right beat after it.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

    typedef enum logic {
        CLK_RUN    = 1'b0,
        CLK_FROZEN = 1'b1
    } clk_state_e;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_DRIVE  = 2'd1,
        RD_MASKED = 2'd2
    } rd_state_e;

    typedef enum logic {
        WR_IDLE  = 1'b0,
        WR_BURST = 1'b1
    } wr_state_e;

endpackage

// File: rtl/sdq_suspend_ctl.sv
module sdq_suspend_ctl
    import sdq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    output logic frozen,
    output logic advance
);

    clk_state_e st_q, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CLK_RUN;
        else        st_q <= st_nx;
    end

    always_comb begin
        unique case (st_q)
            CLK_RUN:    st_nx = cke ? CLK_RUN : CLK_FROZEN;
            CLK_FROZEN: st_nx = cke ? CLK_RUN : CLK_FROZEN;
            default:    st_nx = CLK_RUN;
        endcase
    end

    always_comb begin
        frozen  = (st_q == CLK_FROZEN);
        advance = (st_q == CLK_RUN);
    end

    // R8
    frz_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !cke) |=> frozen);

    // R9
    frz_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && cke) |=> advance);

endmodule

// File: rtl/sdq_read_path.sv
module sdq_read_path
    import sdq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MASK_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              dqm,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out
);

    logic [MASK_LAT-1:0] mask_q;
    logic [MASK_LAT:0]   mask_chain;
    logic                mask_due;
    rd_state_e           st_q, st_nx;
    logic [DATA_W-1:0]   dq_q, dq_nx;

    assign mask_chain = {mask_q, dqm};
    assign mask_due   = mask_q[MASK_LAT-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (advance) mask_q <= mask_chain[MASK_LAT-1:0];
    end

    always_comb begin
        st_nx = st_q;
        if (advance) begin
            if (!rd_valid)     st_nx = RD_IDLE;
            else if (mask_due) st_nx = RD_MASKED;
            else               st_nx = RD_DRIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RD_IDLE;
            dq_q <= '0;
        end else begin
            st_q <= st_nx;
            dq_q <= dq_nx;
        end
    end

    always_comb begin
        dq_nx = dq_q;
        unique case (st_nx)
            RD_DRIVE:  dq_nx = advance ? rd_data : dq_q;
            RD_MASKED: dq_nx = '0;
            RD_IDLE:   dq_nx = '0;
            default:   dq_nx = '0;
        endcase
    end

    always_comb begin
        dq_oe  = (st_q == RD_DRIVE);
        dq_out = dq_q;
    end

    // R2
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && rd_valid && !mask_due) |=> (dq_oe && dq_out == $past(rd_data)));

    // R3
    rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && rd_valid && mask_due) |=> (!dq_oe && dq_out == '0));

    // R4
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !rd_valid) |=> !dq_oe);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> ($stable(dq_oe) && $stable(dq_out) && $stable(mask_q)));

endmodule

// File: rtl/sdq_write_path.sv
module sdq_write_path
    import sdq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4,
    localparam int POS_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              dqm,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_word,
    output logic [POS_W-1:0]  wr_pos
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BURST_LEN - 1);

    wr_state_e        st_q, st_nx;
    logic [POS_W-1:0] pos_q, pos_nx;

    always_comb begin
        st_nx  = st_q;
        pos_nx = pos_q;
        if (advance) begin
            unique case (st_q)
                WR_IDLE, WR_BURST: begin
                    if (!wr_valid || pos_q == LAST_POS) begin
                        st_nx  = WR_IDLE;
                        pos_nx = '0;
                    end else begin
                        st_nx  = WR_BURST;
                        pos_nx = pos_q + 1'b1;
                    end
                end
                default: begin
                    st_nx  = WR_IDLE;
                    pos_nx = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WR_IDLE;
            pos_q <= '0;
        end else begin
            st_q  <= st_nx;
            pos_q <= pos_nx;
        end
    end

    always_comb begin
        wr_en   = rst_n && advance && wr_valid && !dqm;
        wr_word = wr_data;
        wr_pos  = pos_q;
    end

    // R6
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wr_valid && wr_pos != LAST_POS) |=> (wr_pos == $past(wr_pos) + 1'b1));

    // R7
    wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && (!wr_valid || wr_pos == LAST_POS)) |=> (wr_pos == '0));

    // R5
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dqm |-> !wr_en);

    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(wr_pos));

endmodule

// File: rtl/sdram_dq_ctrl.sv
module sdram_dq_ctrl
    import sdq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4,
    parameter int MASK_LAT  = 2,
    localparam int POS_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              dqm,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_word,
    output logic [POS_W-1:0]  wr_pos,
    output logic              frozen
);

    logic advance;

    sdq_suspend_ctl u_susp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke     (cke),
        .frozen  (frozen),
        .advance (advance)
    );

    sdq_read_path #(
        .DATA_W   (DATA_W),
        .MASK_LAT (MASK_LAT)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .dqm      (dqm),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .dq_oe    (dq_oe),
        .dq_out   (dq_out)
    );

    sdq_write_path #(
        .DATA_W    (DATA_W),
        .BURST_LEN (BURST_LEN)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .dqm      (dqm),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .wr_pos   (wr_pos)
    );

    // R10
    frz_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !wr_en);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!dq_oe && !wr_en && !frozen));

endmodule

// File: tb/sdram_dq_ctrl_test.sv
module sdram_dq_ctrl_test;

    localparam int DW = 16;
    localparam int BL = 4;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1;
    logic          dqm = 1'b0;
    logic          rd_valid = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          dq_oe;
    logic [DW-1:0] dq_out;
    logic          wr_en;
    logic [DW-1:0] wr_word;
    logic [PW-1:0] wr_pos;
    logic          frozen;

    always #4 clk = ~clk;

    sdram_dq_ctrl #(.DATA_W(DW), .BURST_LEN(BL), .MASK_LAT(2)) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .dqm(dqm),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .dq_oe(dq_oe), .dq_out(dq_out), .wr_en(wr_en),
        .wr_word(wr_word), .wr_pos(wr_pos), .frozen(frozen)
    );

    typedef struct packed {
        logic          wr_en;
        logic [PW-1:0] pos_pre;
        logic [DW-1:0] word;
        logic          oe;
        logic [DW-1:0] dq;
        logic          frz;
        logic [PW-1:0] pos_post;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    int checks = 0;
    int errors = 0;

    // requirement-level reference state
    bit            m_frz;
    bit            m_dqm1, m_dqm2;   // dqm at the last and the one-before-last advancing edge
    bit [PW-1:0]   m_pos;
    bit            m_oe;
    bit [DW-1:0]   m_dq;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit c, input bit d, input bit rv, input logic [DW-1:0] rd,
                       input bit wv, input logic [DW-1:0] wd, input string tag);
        exp_t e;
        bit   adv;
        @(negedge clk);
        cke = c; dqm = d; rd_valid = rv; rd_data = rd; wr_valid = wv; wr_data = wd;
        adv       = !m_frz;
        e.wr_en   = wv && !d && adv;
        e.pos_pre = m_pos;
        e.word    = wd;
        if (adv) begin
            m_oe   = rv && !m_dqm2;
            m_dq   = m_oe ? rd : '0;
            m_dqm2 = m_dqm1;
            m_dqm1 = d;
            if (wv) m_pos = (m_pos == PW'(BL - 1)) ? '0 : m_pos + 1'b1;
            else    m_pos = '0;
        end
        m_frz      = !c;
        e.oe       = m_oe;
        e.dq       = m_dq;
        e.frz      = m_frz;
        e.pos_post = m_pos;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: checks the pre-edge strobe now and the post-edge state one cycle on
    initial begin
        exp_t  pe;
        string pt;
        bit    pend;
        pend = 0;
        forever begin
            @(negedge clk);
            #2;
            if (pend) begin
                check(dq_oe === pe.oe, pt, "dq_oe", 32'(dq_oe), 32'(pe.oe));
                check(dq_out === pe.dq, pt, "dq_out", 32'(dq_out), 32'(pe.dq));
                check(frozen === pe.frz, pt, "frozen", 32'(frozen), 32'(pe.frz));
                check(wr_pos === pe.pos_post, pt, "wr_pos after edge", 32'(wr_pos), 32'(pe.pos_post));
                pend = 0;
            end
            if (exp_q.size() > 0) begin
                pe = exp_q.pop_front();
                pt = tag_q.pop_front();
                check(wr_en === pe.wr_en, pt, "wr_en", 32'(wr_en), 32'(pe.wr_en));
                check(wr_pos === pe.pos_pre, pt, "wr_pos", 32'(wr_pos), 32'(pe.pos_pre));
                check(wr_word === pe.word, pt, "wr_word", 32'(wr_word), 32'(pe.word));
                pend = 1;
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset holds everything quiet even with a write offered
        wr_valid = 1'b1; dqm = 1'b0; rd_valid = 1'b1; rd_data = 16'h1111;
        repeat (3) @(negedge clk);
        #2;
        check(dq_oe === 1'b0, "R1", "dq_oe in reset", 32'(dq_oe), 0);
        check(wr_en === 1'b0, "R1", "wr_en in reset", 32'(wr_en), 0);
        check(frozen === 1'b0, "R1", "frozen in reset", 32'(frozen), 0);
        check(wr_pos === '0, "R1", "wr_pos in reset", 32'(wr_pos), 0);
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        rst_n = 1'b1;
        m_frz = 0; m_dqm1 = 0; m_dqm2 = 0; m_pos = '0; m_oe = 0; m_dq = '0;
        #2;
        check(dq_oe === 1'b0 && frozen === 1'b0, "R1", "state after release",
              32'({dq_oe, frozen}), 0);

        // R2: plain read burst, mask low
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 16'hA000 + 16'(i), 0, '0, "R2");
        cyc(1, 0, 0, '0, 0, '0, "R4");
        cyc(1, 0, 0, '0, 0, '0, "R4");

        // R3: toggling mask silences the beat two advancing edges later
        cyc(1, 1, 1, 16'hB000, 0, '0, "R3");
        cyc(1, 0, 1, 16'hB001, 0, '0, "R3");
        cyc(1, 1, 1, 16'hB002, 0, '0, "R3");
        cyc(1, 0, 1, 16'hB003, 0, '0, "R3");
        cyc(1, 0, 1, 16'hB004, 0, '0, "R3");
        cyc(1, 0, 1, 16'hB005, 0, '0, "R3");

        // R4: no read beat, mask toggling
        cyc(1, 0, 0, 16'hC000, 0, '0, "R4");
        cyc(1, 1, 0, 16'hC001, 0, '0, "R4");
        cyc(1, 0, 0, 16'hC002, 0, '0, "R4");
        cyc(1, 0, 0, 16'hC003, 0, '0, "R4");

        // R5 / R6: write burst with one blocked beat
        cyc(1, 0, 0, '0, 1, 16'hD000, "R5");
        cyc(1, 0, 0, '0, 1, 16'hD001, "R5");
        cyc(1, 1, 0, '0, 1, 16'hD002, "R6");
        cyc(1, 0, 0, '0, 1, 16'hD003, "R6");

        // R7: long stream across the wrap, then a gap cuts a burst
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, '0, 1, 16'hE000 + 16'(i), "R7");
        cyc(1, 0, 0, '0, 0, '0, "R7");
        cyc(1, 0, 0, '0, 1, 16'hE100, "R7");

        // R8 / R9 / R10: freeze inside a read burst, mask given before freeze
        cyc(1, 0, 0, '0, 0, '0, "R7");
        cyc(1, 1, 1, 16'hF000, 0, '0, "R8");
        cyc(0, 0, 1, 16'hF001, 0, '0, "R8");
        cyc(0, 1, 0, 16'hF0FF, 0, '0, "R10");
        cyc(0, 1, 1, 16'hF0EE, 0, '0, "R10");
        cyc(1, 0, 0, 16'hF0DD, 0, '0, "R9");
        cyc(1, 0, 1, 16'hF002, 0, '0, "R9");
        cyc(1, 0, 1, 16'hF003, 0, '0, "R10");
        cyc(1, 0, 1, 16'hF004, 0, '0, "R2");

        // R10: freeze inside a write burst
        cyc(1, 0, 0, '0, 1, 16'h7000, "R6");
        cyc(0, 0, 0, '0, 1, 16'h7001, "R8");
        cyc(0, 0, 0, '0, 1, 16'h7002, "R10");
        cyc(1, 0, 0, '0, 1, 16'h7003, "R9");
        cyc(1, 0, 0, '0, 1, 16'h7004, "R5");
        cyc(1, 0, 0, '0, 1, 16'h7005, "R7");

        for (int i = 0; i < 3; i++) cyc(1, 0, 0, '0, 0, '0, "R4");
        repeat (3) @(negedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule